// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bank

This block holds the general-purpose I/O ports of a small microcontroller core. It has four 8-bit ports and no direction register. Each pin bit has an output latch that the CPU writes. A 0 in the latch turns the pin's pull-down on, so the pin is driven low. A 1 turns the pull-down off and leaves a pull-up enabled. An outside device may then drive the pin, and the CPU reads the level it drives.

The CPU reads one port at a time from one of two sources: the stored latch byte, or the pin byte after a two-flop synchronizer. The two can differ, for example when a latch holds 1 and a device pulls the pin low.

Port 0 never enables a pull-up, so its pins act as open-drain outputs. On port 3, each bit can be handed on its own to a peripheral signal. A peripheral output can only pull such a pin low while that bit's latch holds 1. Port 3 pin levels are also passed back to the peripherals in synchronized form.

Pads are modelled as two enables per bit (pull-down and pull-up) plus the resolved external level. Port p bit b lives at index 8p+b of every 32-bit pin vector, and bit 0 is the LSB of the port byte.

Top module: `qb_port_bank`

## Requirements
- R1: After reset all four latches hold 0xFF. Every pd_en bit is 0, and reading any port with rd_src=0 returns 0xFF.
- R2: With wr_en=1, wr_sel=p and a 0 in bit b of wr_data, pd_en[8p+b] is 1 and pu_en[8p+b] is 0 from the next cycle on (no alternate override applies here).
- R3: A 1 written to a latch bit clears pd_en for that bit from the next cycle on. It sets pu_en for that bit on ports 1, 2 and 3.
- R4: With rd_src=0, rd_data returns the latch byte of port rd_sel, whatever the pin levels are.
- R5: With rd_src=1, rd_data returns pin_in[8*rd_sel +: 8] as it was sampled two rising clock edges earlier.
- R6: pu_en[7:0] (port 0) is always 0.
- R7: When alt_en[b]=1, the effective level of port 3 bit b is latch[b] AND alt_out[b]. pd_en[24+b] is its inverse and pu_en[24+b] equals it.
- R8: When alt_en[b]=0, alt_out[b] has no effect on pd_en[24+b] or pu_en[24+b]. Ports 0 to 2 ignore alt_en and alt_out entirely.
- R9: A write changes only the latch of port wr_sel. The pd_en and pu_en bits of the other three ports stay as they were.
- R10: alt_in equals pin_in[31:24] delayed by two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Write strobe for a port latch |
| wr_sel | input | 2 | Port index for the write |
| wr_data | input | 8 | Byte written to the selected latch |
| rd_sel | input | 2 | Port index for the read |
| rd_src | input | 1 | 0 reads the latch, 1 reads the synchronized pins |
| rd_data | output | 8 | Read byte |
| pin_in | input | 32 | Resolved external pin levels, port p at bits 8p+7..8p |
| alt_en | input | 8 | Per-bit hand-over of port 3 to a peripheral |
| alt_out | input | 8 | Peripheral output levels for port 3 |
| alt_in | output | 8 | Synchronized port 3 pin levels for the peripherals |
| pd_en | output | 32 | Pull-down enable per pin |
| pu_en | output | 32 | Pull-up enable per pin |

## Verification
Random writes, read selections, pin levels and port 3 hand-over masks are run against a bench model of the latches and the synchronizer. This shows that writes reach only the selected port, and that the latch path and the pin path stay separate even when their values disagree. Directed sequences cover three cases: a latch and a pin that disagree (latch path against pin path), a pin change read back one edge and then two edges later (which fixes the synchronizer depth), and alt_out toggled while its alt_en bit is clear and then while it is set (ignored input against override). Port 0 is driven with all-ones latches so that any pull-up on it would show.

// File: rtl/qb_pkg.sv
package qb_pkg;
  localparam int unsigned QB_NPORT = 4;
  localparam int unsigned QB_WIDTH = 8;
  typedef enum logic {SRC_LATCH = 1'b0, SRC_PIN = 1'b1} rd_src_e;
endpackage

// File: rtl/qb_latch.sv
module qb_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/qb_sync.sv
module qb_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      y      <= '1;
    end else begin
      meta_q <= a;
      y      <= meta_q;
    end
  end
endmodule

// File: rtl/qb_drive.sv
module qb_drive #(
  parameter int unsigned W      = 8,
  parameter bit          PULLUP = 1'b1,
  parameter bit          ALT    = 1'b0
) (
  input  logic [W-1:0] latch,
  input  logic [W-1:0] alt_en,
  input  logic [W-1:0] alt_out,
  output logic [W-1:0] pd,
  output logic [W-1:0] pu
);
  logic [W-1:0] eff;

  generate
    if (ALT) begin : g_alt
      assign eff = latch & (~alt_en | alt_out);
    end else begin : g_plain
      logic [2*W-1:0] unused_alt;
      assign unused_alt = {alt_en, alt_out};
      assign eff = latch;
    end
    if (PULLUP) begin : g_pu
      assign pu = eff;
    end else begin : g_od
      assign pu = '0;
    end
  endgenerate

  assign pd = ~eff;
endmodule

// File: rtl/qb_port_bank.sv
module qb_port_bank #(
  parameter int unsigned NPORT    = qb_pkg::QB_NPORT,
  parameter int unsigned W        = qb_pkg::QB_WIDTH,
  parameter int unsigned OD_PORT  = 0,
  parameter int unsigned ALT_PORT = 3,
  localparam int unsigned SW      = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int unsigned NB      = NPORT * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [SW-1:0] rd_sel,
  input  logic          rd_src,
  output logic [W-1:0]  rd_data,
  input  logic [NB-1:0] pin_in,
  input  logic [W-1:0]  alt_en,
  input  logic [W-1:0]  alt_out,
  output logic [W-1:0]  alt_in,
  output logic [NB-1:0] pd_en,
  output logic [NB-1:0] pu_en
);
  import qb_pkg::*;

  logic [W-1:0]  lat   [NPORT];
  logic [NB-1:0] pin_s;

  qb_sync #(.W(NB)) u_sync (
    .clk(clk), .rst_n(rst_n), .a(pin_in), .y(pin_s)
  );

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic we_p;
      assign we_p = wr_en && (wr_sel == SW'(p));

      qb_latch #(.W(W)) u_lat (
        .clk(clk), .rst_n(rst_n), .we(we_p), .d(wr_data), .q(lat[p])
      );

      qb_drive #(
        .W(W),
        .PULLUP(p != OD_PORT),
        .ALT(p == ALT_PORT)
      ) u_drv (
        .latch(lat[p]), .alt_en(alt_en), .alt_out(alt_out),
        .pd(pd_en[p*W +: W]), .pu(pu_en[p*W +: W])
      );
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (rd_sel == SW'(p)) begin
        rd_data = (rd_src_e'(rd_src) == SRC_PIN) ? pin_s[p*W +: W] : lat[p];
      end
    end
  end

  assign alt_in = pin_s[ALT_PORT*W +: W];
endmodule

// File: rtl/qb_port_bank_chk.sv
module qb_port_bank_chk #(
  parameter int unsigned NPORT    = 4,
  parameter int unsigned W        = 8,
  parameter int unsigned OD_PORT  = 0,
  parameter int unsigned ALT_PORT = 3,
  localparam int unsigned SW      = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int unsigned NB      = NPORT * W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [SW-1:0] wr_sel,
  input logic [W-1:0]  wr_data,
  input logic [SW-1:0] rd_sel,
  input logic          rd_src,
  input logic [W-1:0]  rd_data,
  input logic [NB-1:0] pin_in,
  input logic [W-1:0]  alt_en,
  input logic [W-1:0]  alt_out,
  input logic [W-1:0]  alt_in,
  input logic [NB-1:0] pd_en,
  input logic [NB-1:0] pu_en
);
  logic [1:0] age_q;
  logic [1:0] age_nxt;

  always_comb begin
    age_nxt = age_q;
    if (age_q != 2'd2) age_nxt = age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_nxt;
  end

  assert_reset_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd0) |-> (pd_en == '0));

  assert_write_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SW'(1)) |=> (pd_en[W +: W] == ~$past(wr_data)));

  assert_write_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SW'(2)) |=> (pu_en[2*W +: W] == $past(wr_data)));

  assert_read_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_src && rd_sel == SW'(1)) |-> (rd_data == ~pd_en[W +: W]));

  assert_read_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2 && rd_src && rd_sel == SW'(2)) |->
      (rd_data == $past(pin_in[2*W +: W], 2)));

  assert_no_pullup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pu_en[OD_PORT*W +: W] == '0);

  assert_alt_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_en[ALT_PORT*W +: W] & alt_en & ~alt_out) == '0));

  assert_other_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SW'(0)) |=> $stable(pd_en[0 +: W]));

  assert_alt_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (alt_in == $past(pin_in[ALT_PORT*W +: W], 2)));
endmodule

bind qb_port_bank qb_port_bank_chk #(
  .NPORT(NPORT), .W(W), .OD_PORT(OD_PORT), .ALT_PORT(ALT_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .rd_sel(rd_sel), .rd_src(rd_src), .rd_data(rd_data),
  .pin_in(pin_in), .alt_en(alt_en), .alt_out(alt_out), .alt_in(alt_in),
  .pd_en(pd_en), .pu_en(pu_en)
);

// File: tb/test_qb_port_bank.sv
module test_qb_port_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [1:0]  rd_sel;
  logic        rd_src;
  logic [7:0]  rd_data;
  logic [31:0] pin_in;
  logic [7:0]  alt_en;
  logic [7:0]  alt_out;
  logic [7:0]  alt_in;
  logic [31:0] pd_en;
  logic [31:0] pu_en;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  m_lat [4];
  logic [31:0] m_s1;
  logic [31:0] m_s2;

  always #4 clk = ~clk;

  qb_port_bank i_qb_port_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_src(rd_src), .rd_data(rd_data),
    .pin_in(pin_in), .alt_en(alt_en), .alt_out(alt_out), .alt_in(alt_in),
    .pd_en(pd_en), .pu_en(pu_en)
  );

  function automatic logic [7:0] eff_of(input int p);
    logic [7:0] e;
    e = m_lat[p];
    if (p == 3) e = e & (~alt_en | alt_out);
    return e;
  endfunction

  function automatic logic [31:0] exp_pd();
    logic [31:0] v;
    for (int p = 0; p < 4; p++) v[p*8 +: 8] = ~eff_of(p);
    return v;
  endfunction

  function automatic logic [31:0] exp_pu();
    logic [31:0] v;
    v[7:0] = 8'h00;
    for (int p = 1; p < 4; p++) v[p*8 +: 8] = eff_of(p);
    return v;
  endfunction

  function automatic logic [7:0] exp_rd();
    return rd_src ? m_s2[rd_sel*8 +: 8] : m_lat[rd_sel];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " R2 R3 R6 R7 R8 R9 pd_en"}, pd_en, exp_pd());
    check({tag, " R3 R6 R7 pu_en"}, pu_en, exp_pu());
    check({tag, " R4 R5 rd_data"}, {24'h0, rd_data}, {24'h0, exp_rd()});
    check({tag, " R10 alt_in"}, {24'h0, alt_in}, {24'h0, m_s2[31:24]});
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (wr_en) m_lat[wr_sel] = wr_data;
    m_s2 = m_s1;
    m_s1 = pin_in;
    @(negedge clk);
    compare_all(tag);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = p; wr_data = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    rd_sel = '0; rd_src = 1'b0; pin_in = 32'hFFFF_FFFF;
    alt_en = '0; alt_out = '1;
    for (int p = 0; p < 4; p++) m_lat[p] = 8'hFF;
    m_s1 = '1; m_s2 = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, latch read of every port
    check("R1 pd_en after reset", pd_en, 32'h0);
    for (int p = 0; p < 4; p++) begin
      rd_sel = 2'(p); #1;
      check("R1 latch read after reset", {24'h0, rd_data}, 32'hFF);
    end
    // R6: all latches 1, port 0 keeps pull-ups off
    check("R6 port0 pu_en", {24'h0, pu_en[7:0]}, 32'h0);

    // R2 / R4 / R5: latch and pin disagree on port 1
    wr(2'd1, 8'h0F); pin_in[15:8] = 8'hAA; rd_sel = 2'd1; rd_src = 1'b0;
    step("R2");
    check("R2 pd_en port1", {24'h0, pd_en[15:8]}, 32'hF0);
    check("R4 latch read ignores pin", {24'h0, rd_data}, 32'h0F);
    rd_src = 1'b1;
    step("R5");
    check("R5 pin read after two edges", {24'h0, rd_data}, 32'hAA);
    pin_in[15:8] = 8'h55;
    step("R5");
    check("R5 pin read one edge after change", {24'h0, rd_data}, 32'hAA);
    step("R5");
    check("R5 pin read two edges after change", {24'h0, rd_data}, 32'h55);

    // R3 / R9: write port 2, other ports untouched
    wr(2'd2, 8'hC3);
    step("R9");
    check("R3 pu_en port2", {24'h0, pu_en[23:16]}, 32'hC3);
    check("R9 port1 pd unchanged", {24'h0, pd_en[15:8]}, 32'hF0);

    // R8: alt_out toggled with alt_en clear on port 3
    alt_en = 8'h00; alt_out = 8'h00; #1;
    check("R8 alt_out ignored", {24'h0, pd_en[31:24]}, 32'h00);
    // R7: override now enabled on bits 0..3
    alt_en = 8'h0F; #1;
    check("R7 alt override pd", {24'h0, pd_en[31:24]}, 32'h0F);
    wr(2'd3, 8'hFE); alt_out = 8'h0E;
    step("R7");
    check("R7 latch 0 wins over alt_out", {24'h0, pd_en[31:24]}, 32'h01);
    pin_in[31:24] = 8'h5A;
    step("R10"); step("R10");
    check("R10 alt_in", {24'h0, alt_in}, 32'h5A);

    // random phase
    for (int i = 0; i < 600; i++) begin
      wr_en   = 1'($urandom);
      wr_sel  = 2'($urandom);
      wr_data = 8'($urandom);
      rd_sel  = 2'($urandom);
      rd_src  = 1'($urandom);
      pin_in  = $urandom;
      alt_en  = 8'($urandom);
      alt_out = 8'($urandom);
      step("rand");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule